// File: doc/BRIEF.md
# Double-Pumped Two-Port Static Memory

This block is a synthesizable model of a small static memory whose read side and write side each move two words per clock cycle. It is clocked by a complementary pair, a true clock and its inverse, and uses one rising edge of each per cycle. One address bus is shared by both sides. Two separate strobes, both active low, start the transfers. When a write is started, the memory takes two words from the data-in bus. The first is taken on the true-clock edge and the second on the inverse-clock edge. The pair is stored at the given address and the next one. When a read is started, the memory returns two words on the data-out bus one cycle later: one in the high phase of the true clock and one in the high phase of the inverse clock.

Both strobes may be active in the same cycle, because the data buses are separate. In that case the read and the write use the same address. A read always sees the array as it stood before any write started in the same cycle. A data-valid flag marks the phases that carry read data. Between reads, the data-out bus keeps showing the last word that was returned.

Top module: `qdr_sram_port`

## Requirements
- R1: While reset is high and after it is released with no read issued, `dout` is all zeros and `dout_valid` is 0.
- R2: A write accepted with `wr_n` low stores the `din` value sampled at that rising `k_clk` edge at address A. It stores the `din` value sampled at the following rising `kb_clk` edge at address A+1, where A is `addr` sampled at the same `k_clk` edge.
- R3: A read accepted with `rd_n` low at a rising `k_clk` edge places the word at address A on `dout`, with `dout_valid` high, during the high phase of `k_clk` after the next rising `k_clk` edge.
- R4: During the high phase of `kb_clk` that follows, `dout` carries the word at address A+1 and `dout_valid` stays high.
- R5: The address A+1 wraps modulo the array depth (2**ADDR_W), for both write bursts and read bursts, so the top address pairs with address 0.
- R6: When a read and a write are accepted at the same edge, the read returns both words as they stood before that write. The write still takes effect for later reads.
- R7: In a cycle with no read data, `dout_valid` is 0 and `dout` holds the last word that was returned, in both clock phases.
- R8: A strobe that is high at a rising `k_clk` edge starts nothing: the array is unchanged and no read data follows.
- R9: Reads accepted on consecutive cycles return their bursts back to back, with no idle phase between them.
- R10: Reset clears every array location to zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| k_clk | input | 1 | True clock; addresses, strobes and first write word captured on its rising edge |
| kb_clk | input | 1 | Inverse clock; second write word captured on its rising edge |
| rst | input | 1 | Synchronous reset, active high |
| rd_n | input | 1 | Read strobe, active low |
| wr_n | input | 1 | Write strobe, active low |
| addr | input | ADDR_W | Shared word address for both sides |
| din | input | DATA_W | Write data, two words per cycle |
| dout | output | DATA_W | Read data, two words per cycle |
| dout_valid | output | 1 | High in the phases in which `dout` carries read data |

## Verification
The bench first fills every location with two-word writes at even addresses. It then reads every address on consecutive cycles. The even addresses show that the word pair lands in the right order, and the odd addresses show that a burst can start in the middle of a written pair. The top address shows the wrap back to address 0. A second pass issues a read and a write together at every address, followed by a read. This separates read-before-write behaviour from a bypass of the new data. Idle cycles and cycles with the strobes held high show that the output holds its value and that nothing is stored.

// File: rtl/qdr_pkg.sv
package qdr_pkg;

    localparam int unsigned DEF_ADDR_W = 4;
    localparam int unsigned DEF_DATA_W = 8;

    // Which half of the cycle a data word belongs to.
    typedef enum logic {
        HALF_LOW  = 1'b0,
        HALF_HIGH = 1'b1
    } half_e;

    // Successor word address inside an array of 2**w words.
    function automatic logic [31:0] wrap_inc(input logic [31:0] a, input int unsigned w);
        logic [31:0] mask;
        mask = (32'd1 << w) - 32'd1;
        return (a + 32'd1) & mask;
    endfunction

endpackage

// File: rtl/qdr_array.sv
module qdr_array #(
    parameter int unsigned ADDR_W = qdr_pkg::DEF_ADDR_W,
    parameter int unsigned DATA_W = qdr_pkg::DEF_DATA_W
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              we,
    input  logic [ADDR_W-1:0] waddr,
    input  logic [DATA_W-1:0] wd0,
    input  logic [DATA_W-1:0] wd1,
    input  logic [ADDR_W-1:0] raddr,
    output logic [DATA_W-1:0] rd0,
    output logic [DATA_W-1:0] rd1
);
    localparam int unsigned DEPTH = 1 << ADDR_W;

    logic [DATA_W-1:0] mem [DEPTH];
    logic [ADDR_W-1:0] waddr_hi;
    logic [ADDR_W-1:0] raddr_hi;

    assign waddr_hi = ADDR_W'(qdr_pkg::wrap_inc(32'(waddr), ADDR_W));
    assign raddr_hi = ADDR_W'(qdr_pkg::wrap_inc(32'(raddr), ADDR_W));

    always_ff @(posedge clk) begin
        if (rst) begin
            for (int i = 0; i < int'(DEPTH); i++) begin
                mem[i] <= '0;
            end
        end else if (we) begin
            mem[waddr]    <= wd0;
            mem[waddr_hi] <= wd1;
        end
    end

    assign rd0 = mem[raddr];
    assign rd1 = mem[raddr_hi];

    // R2
    burst_lo_chk: assert property (@(posedge clk) disable iff (rst)
        we |=> mem[$past(waddr)] == $past(wd0));

    // R5
    burst_hi_chk: assert property (@(posedge clk) disable iff (rst)
        we |=> mem[ADDR_W'($past(waddr) + 1'b1)] == $past(wd1));

endmodule

// File: rtl/qdr_write_side.sv
module qdr_write_side #(
    parameter int unsigned ADDR_W = qdr_pkg::DEF_ADDR_W,
    parameter int unsigned DATA_W = qdr_pkg::DEF_DATA_W
) (
    input  logic              k_clk,
    input  logic              kb_clk,
    input  logic              rst,
    input  logic              wr_n,
    input  logic [ADDR_W-1:0] addr,
    input  logic [DATA_W-1:0] din,
    output logic              commit,
    output logic [ADDR_W-1:0] commit_addr,
    output logic [DATA_W-1:0] commit_w0,
    output logic [DATA_W-1:0] commit_w1
);
    // Rising-clock capture: strobe, address and first word.
    always_ff @(posedge k_clk) begin
        if (rst) begin
            commit      <= 1'b0;
            commit_addr <= '0;
            commit_w0   <= '0;
        end else begin
            commit <= !wr_n;
            if (!wr_n) begin
                commit_addr <= addr;
                commit_w0   <= din;
            end
        end
    end

    // Inverse-clock capture: second word of an accepted burst.
    always_ff @(posedge kb_clk) begin
        if (rst) begin
            commit_w1 <= '0;
        end else if (commit) begin
            commit_w1 <= din;
        end
    end

endmodule

// File: rtl/qdr_read_side.sv
module qdr_read_side #(
    parameter int unsigned ADDR_W = qdr_pkg::DEF_ADDR_W,
    parameter int unsigned DATA_W = qdr_pkg::DEF_DATA_W
) (
    input  logic              k_clk,
    input  logic              kb_clk,
    input  logic              rst,
    input  logic              rd_n,
    input  logic [ADDR_W-1:0] addr,
    output logic [ADDR_W-1:0] fetch_addr,
    input  logic [DATA_W-1:0] fetch_w0,
    input  logic [DATA_W-1:0] fetch_w1,
    output logic [DATA_W-1:0] dout,
    output logic              dout_valid
);
    logic              pend_q;
    logic [DATA_W-1:0] rise_q;
    logic [DATA_W-1:0] stage_q;
    logic [DATA_W-1:0] fall_q;
    logic              vr_q;
    logic              vf_q;
    qdr_pkg::half_e    half;

    // Rising-clock side: accept a read, then fetch both words at once.
    always_ff @(posedge k_clk) begin
        if (rst) begin
            pend_q     <= 1'b0;
            fetch_addr <= '0;
            rise_q     <= '0;
            stage_q    <= '0;
            vr_q       <= 1'b0;
        end else begin
            pend_q <= !rd_n;
            if (!rd_n) begin
                fetch_addr <= addr;
            end
            vr_q <= pend_q;
            if (pend_q) begin
                rise_q  <= fetch_w0;
                stage_q <= fetch_w1;
            end else begin
                rise_q  <= fall_q;
            end
        end
    end

    // Inverse-clock side: second word of the burst.
    always_ff @(posedge kb_clk) begin
        if (rst) begin
            fall_q <= '0;
            vf_q   <= 1'b0;
        end else begin
            vf_q <= vr_q;
            if (vr_q) begin
                fall_q <= stage_q;
            end
        end
    end

    assign half       = k_clk ? qdr_pkg::HALF_HIGH : qdr_pkg::HALF_LOW;
    assign dout       = (half == qdr_pkg::HALF_HIGH) ? rise_q : fall_q;
    assign dout_valid = (half == qdr_pkg::HALF_HIGH) ? vr_q : vf_q;

    // R3
    read_latency_chk: assert property (@(posedge k_clk) disable iff (rst)
        !rd_n |=> ##1 vr_q);

    // R7
    idle_valid_low_chk: assert property (@(posedge k_clk) disable iff (rst)
        rd_n |=> ##1 !vr_q);

    // R4
    fall_follows_chk: assert property (@(posedge kb_clk) disable iff (rst)
        vr_q |=> vf_q);

endmodule

// File: rtl/qdr_sram_port.sv
module qdr_sram_port #(
    parameter int unsigned ADDR_W = qdr_pkg::DEF_ADDR_W,
    parameter int unsigned DATA_W = qdr_pkg::DEF_DATA_W
) (
    input  logic              k_clk,
    input  logic              kb_clk,
    input  logic              rst,
    input  logic              rd_n,
    input  logic              wr_n,
    input  logic [ADDR_W-1:0] addr,
    input  logic [DATA_W-1:0] din,
    output logic [DATA_W-1:0] dout,
    output logic              dout_valid
);
    logic              commit;
    logic [ADDR_W-1:0] commit_addr;
    logic [DATA_W-1:0] commit_w0;
    logic [DATA_W-1:0] commit_w1;
    logic [ADDR_W-1:0] fetch_addr;
    logic [DATA_W-1:0] fetch_w0;
    logic [DATA_W-1:0] fetch_w1;

    qdr_write_side #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) wr_side_i (
        .k_clk       (k_clk),
        .kb_clk      (kb_clk),
        .rst         (rst),
        .wr_n        (wr_n),
        .addr        (addr),
        .din         (din),
        .commit      (commit),
        .commit_addr (commit_addr),
        .commit_w0   (commit_w0),
        .commit_w1   (commit_w1)
    );

    qdr_array #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) array_i (
        .clk   (k_clk),
        .rst   (rst),
        .we    (commit),
        .waddr (commit_addr),
        .wd0   (commit_w0),
        .wd1   (commit_w1),
        .raddr (fetch_addr),
        .rd0   (fetch_w0),
        .rd1   (fetch_w1)
    );

    qdr_read_side #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) rd_side_i (
        .k_clk      (k_clk),
        .kb_clk     (kb_clk),
        .rst        (rst),
        .rd_n       (rd_n),
        .addr       (addr),
        .fetch_addr (fetch_addr),
        .fetch_w0   (fetch_w0),
        .fetch_w1   (fetch_w1),
        .dout       (dout),
        .dout_valid (dout_valid)
    );

endmodule

// File: tb/qdr_sram_port_tb_top.sv
`timescale 1ns/1ps
module qdr_sram_port_tb_top;
    localparam int unsigned AW    = 4;
    localparam int unsigned DW    = 8;
    localparam int unsigned DEPTH = 1 << AW;

    logic          k_clk = 1'b0;
    logic          kb_clk = 1'b1;
    logic          rst = 1'b1;
    logic          rd_n = 1'b1;
    logic          wr_n = 1'b1;
    logic [AW-1:0] addr = '0;
    logic [DW-1:0] din = '0;
    logic [DW-1:0] dout;
    logic          dout_valid;

    int checks = 0;
    int errors = 0;

    logic [DW-1:0] model [DEPTH];
    logic          pend = 1'b0;
    logic [DW-1:0] e0 = '0;
    logic [DW-1:0] e1 = '0;
    logic [DW-1:0] last = '0;
    string         pend_tag = "R3";

    always #5 begin
        k_clk  = ~k_clk;
        kb_clk = ~kb_clk;
    end

    qdr_sram_port #(.ADDR_W(AW), .DATA_W(DW)) dut_i (
        .k_clk      (k_clk),
        .kb_clk     (kb_clk),
        .rst        (rst),
        .rd_n       (rd_n),
        .wr_n       (wr_n),
        .addr       (addr),
        .din        (din),
        .dout       (dout),
        .dout_valid (dout_valid)
    );

    task automatic check(input string tag, input logic [DW-1:0] d_exp, input logic v_exp);
        checks++;
        if (dout !== d_exp || dout_valid !== v_exp) begin
            errors++;
            $display("FAIL %s: dout=%h valid=%b expected dout=%h valid=%b",
                     tag, dout, dout_valid, d_exp, v_exp);
        end
    endtask

    function automatic logic [DW-1:0] pat(input int i, input int salt);
        return DW'((i * 37 + salt * 11 + 5) & ((1 << DW) - 1));
    endfunction

    // One full clock cycle; entered 2.5 ns before a rising k_clk edge.
    task automatic cyc(input logic rd, input logic wr, input logic [AW-1:0] a,
                       input logic [DW-1:0] d0, input logic [DW-1:0] d1, input string tag);
        logic [AW-1:0] a1;
        a1   = a + 1'b1;
        rd_n = !rd;
        wr_n = !wr;
        addr = a;
        din  = d0;
        @(posedge k_clk); #2.5;
        din  = d1;
        rd_n = 1'b1;
        wr_n = 1'b1;
        if (pend) begin
            check(pend_tag, e0, 1'b1);
            last = e0;
        end else begin
            check("R7", last, 1'b0);
        end
        @(posedge kb_clk); #2.5;
        if (pend) begin
            check(pend_tag, e1, 1'b1);
            last = e1;
        end else begin
            check("R7", last, 1'b0);
        end
        // Reads see the array before a write accepted at the same edge (R6).
        pend = rd;
        if (rd) begin
            e0 = model[a];
            e1 = model[a1];
            pend_tag = tag;
        end
        if (wr) begin
            model[a]  = d0;
            model[a1] = d1;
        end
    endtask

    initial begin
        #(200000 * 10);
        errors++;
        $display("FAIL watchdog: run did not complete, expected completion");
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        for (int i = 0; i < int'(DEPTH); i++) model[i] = '0;
        // Reset phase (R1)
        repeat (3) @(posedge k_clk);
        #2.5;
        check("R1", '0, 1'b0);
        @(posedge kb_clk); #2.5;
        check("R1", '0, 1'b0);
        rst = 1'b0;
        cyc(1'b0, 1'b0, '0, '0, '0, "R1");
        cyc(1'b0, 1'b0, '0, '0, '0, "R1");

        // Cleared array (R10)
        cyc(1'b1, 1'b0, 4'd3, '0, '0, "R10");
        cyc(1'b1, 1'b0, 4'd15, '0, '0, "R10");
        cyc(1'b0, 1'b0, '0, '0, '0, "R7");

        // Fill with pairs at even addresses (R2)
        for (int i = 0; i < int'(DEPTH); i += 2)
            cyc(1'b0, 1'b1, AW'(i), pat(i, 0), pat(i + 1, 0), "R2");

        // Back-to-back reads of every address (R2 R4 R9, wrap R5)
        for (int i = 0; i < int'(DEPTH); i++)
            cyc(1'b1, 1'b0, AW'(i), '0, '0, (i == int'(DEPTH) - 1) ? "R5" : ((i % 2) ? "R9" : "R2"));

        // Idle hold (R7)
        repeat (3) cyc(1'b0, 1'b0, 4'd6, 8'hAA, 8'h55, "R7");

        // Strobes high: nothing stored, nothing read (R8)
        cyc(1'b0, 1'b0, 4'd2, 8'hE1, 8'hE2, "R8");
        cyc(1'b1, 1'b0, 4'd2, '0, '0, "R8");
        cyc(1'b0, 1'b0, '0, '0, '0, "R7");

        // Wrapping write burst at the top address (R5)
        cyc(1'b0, 1'b1, 4'd15, 8'h3C, 8'hC3, "R5");
        cyc(1'b1, 1'b0, 4'd15, '0, '0, "R5");
        cyc(1'b1, 1'b0, 4'd0, '0, '0, "R5");
        cyc(1'b0, 1'b0, '0, '0, '0, "R7");

        // Read and write together at each address, then read back (R6)
        for (int i = 0; i < int'(DEPTH); i++) begin
            cyc(1'b1, 1'b1, AW'(i), pat(i, 3), pat(i + 1, 3), "R6");
            cyc(1'b1, 1'b0, AW'(i), '0, '0, "R6");
        end
        cyc(1'b0, 1'b0, '0, '0, '0, "R7");
        cyc(1'b0, 1'b0, '0, '0, '0, "R7");

        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end
endmodule